// File: doc/BRIEF.md
# Micro-op Reorder Ring

This block keeps track of decoded micro-ops between the moment they enter the out-of-order back end and the moment their results become architecturally permanent. Micro-ops are written in program order into a ring of slots at the tail. Each slot holds the fetch address of the instruction that produced the micro-op, its operation code, the architectural destination register and the physical register allocated to it by renaming. Each slot also holds a progress state.

The execution side reports progress by naming a slot index. A dispatch report moves a slot from waiting to issued. A completion report moves it from issued to done. These reports may arrive in any order across slots. Every cycle, the ring retires a contiguous run of done slots from the head, oldest first, up to a parameter-set width. Each retired slot is shown on its own retire lane. A younger micro-op that has finished sits in the ring until every older one has retired. The depth is a parameter and need not be a power of two; by default it is 126 slots.

Top module: `uop_reorder_ring`

## Requirements
- R1: After reset the ring is empty: `rob_empty` is 1, `alloc_full` is 0, `rob_occupancy` is 0, `alloc_idx` is 0, no retire lane is valid and both error flags are 0.
- R2: When `alloc_valid` is 1 and `alloc_full` is 0, the micro-op is written into slot `alloc_idx` in the waiting state. The tail index then advances by one and wraps from DEPTH-1 to 0.
- R3: `alloc_full` is 1 exactly when DEPTH slots are occupied. An allocation offered while it is 1 is dropped: occupancy and `alloc_idx` do not change because of it.
- R4: A dispatch report naming a slot in the waiting state moves that slot to the issued state. Slots may be dispatched in any order.
- R5: A completion report naming a slot in the issued state moves that slot to the done state.
- R6: Each cycle, retire lane k is valid when the slot k places past the head is occupied and done, and every lane below k is also valid. At most RET_W slots retire per cycle. Each valid lane carries the address, operation, architectural and physical register written at allocation. The retired slots are freed at the next clock edge, and the head advances by the number retired.
- R7: Retirement is strictly in program order. A done slot behind a slot that is not done does not retire, and the valid lanes always form a prefix starting at lane 0.
- R8: A dispatch report whose index is at least DEPTH, or whose slot is not in the waiting state, changes no slot. It sets `disp_err` to 1 in the following cycle only.
- R9: A completion report whose index is at least DEPTH, or whose slot is not in the issued state, changes no slot. It sets `cmpl_err` to 1 in the following cycle only.
- R10: `rob_occupancy` equals the number of allocated slots not yet retired, and `rob_empty` is 1 exactly when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Offer a micro-op at the tail |
| alloc_pc | input | PC_W | Address of the producing instruction |
| alloc_op | input | OP_W | Operation code |
| alloc_areg | input | AREG_W | Architectural destination register |
| alloc_preg | input | PREG_W | Physical register mapped to it |
| alloc_full | output | 1 | All slots occupied; offers are dropped |
| alloc_idx | output | IDX_W | Slot that the next accepted micro-op takes |
| rob_empty | output | 1 | No slot occupied |
| rob_occupancy | output | CNT_W | Number of occupied slots |
| disp_valid | input | 1 | Dispatch report present |
| disp_idx | input | IDX_W | Slot being dispatched |
| cmpl_valid | input | 1 | Completion report present |
| cmpl_idx | input | IDX_W | Slot that completed |
| disp_err | output | 1 | Previous cycle's dispatch report was rejected |
| cmpl_err | output | 1 | Previous cycle's completion report was rejected |
| ret_valid | output | RET_W | Per-lane retire valid, lane 0 oldest |
| ret_pc | output | RET_W x PC_W | Address of each retiring micro-op |
| ret_op | output | RET_W x OP_W | Operation of each retiring micro-op |
| ret_areg | output | RET_W x AREG_W | Architectural register of each lane |
| ret_preg | output | RET_W x PREG_W | Physical register of each lane |

## Verification
The hardest states to reach are those where the full-width retire window straddles the wrap from slot 125 to slot 0, and where a younger slot finished long before the head blocks it. The stimulus therefore first fills the ring to the brim and offers more micro-ops while it is full. It then completes slots at random positions inside the occupied span, so that done slots pile up behind unfinished ones. A long mixed phase follows, with allocation, dispatch and completion all active, which carries both pointers around the ring several times. Throughout, a share of the reports is aimed at slots in the wrong state or beyond the depth, so the rejection path is exercised next to legal traffic.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;

   // Progress of one ring slot; FREE means not part of the occupied span.
   typedef enum logic [1:0] {
      SLOT_FREE   = 2'd0,
      SLOT_WAIT   = 2'd1,
      SLOT_ISSUED = 2'd2,
      SLOT_DONE   = 2'd3
   } slot_state_e;

   // Modular advance of a ring position.
   function automatic int ring_add(input int pos, input int step, input int depth);
      int s;
      s = pos + step;
      if (s >= depth) s = s - depth;
      return s;
   endfunction

endpackage

// File: rtl/rob_ptrs.sv
`timescale 1ns/1ps
module rob_ptrs #(
   parameter int DEPTH = 126,
   parameter int IDX_W = 7,
   parameter int CNT_W = 7,
   parameter int RCW   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_fire,
   input  logic [RCW-1:0]   ret_cnt,
   output logic [IDX_W-1:0] head,
   output logic [IDX_W-1:0] tail,
   output logic [CNT_W-1:0] count
);
   import rob_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         head  <= IDX_W'(ring_add(int'(head), int'(ret_cnt), DEPTH));
         if (alloc_fire)
            tail <= IDX_W'(ring_add(int'(tail), 1, DEPTH));
         count <= count + CNT_W'(alloc_fire) - CNT_W'(ret_cnt);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      int'(count) <= DEPTH); // R3
   AST_TAIL_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
      int'(tail) < DEPTH && int'(head) < DEPTH); // R2
   AST_SPAN_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      ((int'(tail) - int'(head) + DEPTH) % DEPTH) == (int'(count) % DEPTH)); // R10

endmodule

// File: rtl/rob_slots.sv
`timescale 1ns/1ps
module rob_slots #(
   parameter int DEPTH = 126,
   parameter int IDX_W = 7,
   parameter int PAY_W = 52,
   parameter int RET_W = 3,
   parameter int RCW   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 alloc_fire,
   input  logic [IDX_W-1:0]     tail,
   input  logic [PAY_W-1:0]     alloc_pay,
   input  logic                 disp_valid,
   input  logic [IDX_W-1:0]     disp_idx,
   input  logic                 cmpl_valid,
   input  logic [IDX_W-1:0]     cmpl_idx,
   input  logic [IDX_W-1:0]     lane_idx [RET_W],
   input  logic [RCW-1:0]       ret_cnt,
   output rob_pkg::slot_state_e lane_st  [RET_W],
   output logic [PAY_W-1:0]     lane_pay [RET_W],
   output logic                 disp_err,
   output logic                 cmpl_err
);
   import rob_pkg::*;

   slot_state_e      st_q  [DEPTH];
   logic [PAY_W-1:0] pay_q [DEPTH];

   logic        disp_in_ring, cmpl_in_ring;
   slot_state_e disp_cur, cmpl_cur;
   logic        disp_hit, cmpl_hit;

   always_comb begin
      disp_in_ring = int'(disp_idx) < DEPTH;
      cmpl_in_ring = int'(cmpl_idx) < DEPTH;
      disp_cur = disp_in_ring ? st_q[disp_idx] : SLOT_FREE;
      cmpl_cur = cmpl_in_ring ? st_q[cmpl_idx] : SLOT_FREE;
      disp_hit = disp_valid && disp_in_ring && (disp_cur == SLOT_WAIT);
      cmpl_hit = cmpl_valid && cmpl_in_ring && (cmpl_cur == SLOT_ISSUED);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) st_q[i] <= SLOT_FREE;
         disp_err <= 1'b0;
         cmpl_err <= 1'b0;
      end else begin
         for (int k = 0; k < RET_W; k++)
            if (RCW'(k) < ret_cnt) st_q[lane_idx[k]] <= SLOT_FREE;
         if (disp_hit)   st_q[disp_idx] <= SLOT_ISSUED;
         if (cmpl_hit)   st_q[cmpl_idx] <= SLOT_DONE;
         if (alloc_fire) st_q[tail]     <= SLOT_WAIT;
         disp_err <= disp_valid && !disp_hit;
         cmpl_err <= cmpl_valid && !cmpl_hit;
      end
   end

   always_ff @(posedge clk) begin
      if (alloc_fire) pay_q[tail] <= alloc_pay;
   end

   generate
      for (genvar k = 0; k < RET_W; k++) begin : g_lane
         assign lane_st[k]  = st_q[lane_idx[k]];
         assign lane_pay[k] = pay_q[lane_idx[k]];
      end
   endgenerate

   AST_ISSUE_TAKES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      disp_hit |=> st_q[$past(disp_idx)] == SLOT_ISSUED); // R4
   AST_DONE_TAKES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_hit |=> st_q[$past(cmpl_idx)] == SLOT_DONE); // R5
   AST_ALLOC_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_fire |-> st_q[tail] == SLOT_FREE); // R2

endmodule

// File: rtl/rob_retire_pick.sv
`timescale 1ns/1ps
module rob_retire_pick #(
   parameter int RET_W = 3,
   parameter int CNT_W = 7,
   parameter int RCW   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  rob_pkg::slot_state_e lane_st [RET_W],
   input  logic [CNT_W-1:0]     count,
   output logic [RET_W-1:0]     ret_mask,
   output logic [RCW-1:0]       ret_cnt
);
   import rob_pkg::*;

   always_comb begin
      logic run;
      run     = 1'b1;
      ret_cnt = '0;
      for (int k = 0; k < RET_W; k++) begin
         run         = run && (CNT_W'(k) < count) && (lane_st[k] == SLOT_DONE);
         ret_mask[k] = run;
         ret_cnt     = ret_cnt + RCW'(run);
      end
   end

   generate
      for (genvar k = 1; k < RET_W; k++) begin : g_prefix
         AST_RET_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
            ret_mask[k] |-> ret_mask[k-1]); // R7
      end
   endgenerate

   AST_RET_WITHIN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ret_cnt) <= int'(count)); // R6
   AST_HEAD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ret_mask[0] |-> lane_st[0] == SLOT_DONE); // R7

endmodule

// File: rtl/uop_reorder_ring.sv
`timescale 1ns/1ps
module uop_reorder_ring #(
   parameter int DEPTH  = 126,
   parameter int RET_W  = 3,
   parameter int PC_W   = 32,
   parameter int OP_W   = 8,
   parameter int AREG_W = 5,
   parameter int PREG_W = 7,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           alloc_valid,
   input  logic [PC_W-1:0]                alloc_pc,
   input  logic [OP_W-1:0]                alloc_op,
   input  logic [AREG_W-1:0]              alloc_areg,
   input  logic [PREG_W-1:0]              alloc_preg,
   output logic                           alloc_full,
   output logic [IDX_W-1:0]               alloc_idx,
   output logic                           rob_empty,
   output logic [CNT_W-1:0]               rob_occupancy,
   input  logic                           disp_valid,
   input  logic [IDX_W-1:0]               disp_idx,
   input  logic                           cmpl_valid,
   input  logic [IDX_W-1:0]               cmpl_idx,
   output logic                           disp_err,
   output logic                           cmpl_err,
   output logic [RET_W-1:0]               ret_valid,
   output logic [RET_W-1:0][PC_W-1:0]     ret_pc,
   output logic [RET_W-1:0][OP_W-1:0]     ret_op,
   output logic [RET_W-1:0][AREG_W-1:0]   ret_areg,
   output logic [RET_W-1:0][PREG_W-1:0]   ret_preg
);
   import rob_pkg::*;

   localparam int PAY_W = PC_W + OP_W + AREG_W + PREG_W;
   localparam int RCW   = $clog2(RET_W + 1);

   generate
      if (DEPTH < 2)     begin : g_bad_depth $error("ring depth must be at least 2"); end
      if (RET_W < 1)     begin : g_bad_ret   $error("retire width must be at least 1"); end
      if (RET_W > DEPTH) begin : g_bad_span  $error("retire width exceeds ring depth"); end
   endgenerate

   logic [IDX_W-1:0] head, tail;
   logic [CNT_W-1:0] count;
   logic             alloc_fire;
   logic [RCW-1:0]   ret_cnt;
   logic [IDX_W-1:0] lane_idx [RET_W];
   slot_state_e      lane_st  [RET_W];
   logic [PAY_W-1:0] lane_pay [RET_W];

   assign alloc_full    = int'(count) == DEPTH;
   assign rob_empty     = count == '0;
   assign rob_occupancy = count;
   assign alloc_idx     = tail;
   assign alloc_fire    = alloc_valid && !alloc_full;

   generate
      for (genvar k = 0; k < RET_W; k++) begin : g_ret
         assign lane_idx[k] = IDX_W'(ring_add(int'(head), k, DEPTH));
         assign {ret_pc[k], ret_op[k], ret_areg[k], ret_preg[k]} = lane_pay[k];
      end
   endgenerate

   rob_ptrs #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .RCW(RCW)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .ret_cnt(ret_cnt),
      .head(head), .tail(tail), .count(count));

   rob_slots #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PAY_W(PAY_W), .RET_W(RET_W), .RCW(RCW)) u_slots (
      .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .tail(tail),
      .alloc_pay({alloc_pc, alloc_op, alloc_areg, alloc_preg}),
      .disp_valid(disp_valid), .disp_idx(disp_idx),
      .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx),
      .lane_idx(lane_idx), .ret_cnt(ret_cnt),
      .lane_st(lane_st), .lane_pay(lane_pay),
      .disp_err(disp_err), .cmpl_err(cmpl_err));

   rob_retire_pick #(.RET_W(RET_W), .CNT_W(CNT_W), .RCW(RCW)) u_pick (
      .clk(clk), .rst_n(rst_n), .lane_st(lane_st), .count(count),
      .ret_mask(ret_valid), .ret_cnt(ret_cnt));

   AST_EMPTY_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      rob_empty |-> ret_valid == '0); // R10
   AST_FULL_HOLDS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_full |=> tail == $past(tail)); // R3
   AST_ERR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(disp_valid) |-> !disp_err); // R8
   AST_CERR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cmpl_valid) |-> !cmpl_err); // R9

endmodule

// File: tb/tb_uop_reorder_ring.sv
`timescale 1ns/1ps
module tb_uop_reorder_ring;

   localparam int D  = 126;
   localparam int RW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;  // 125 MHz

   logic                 alloc_valid = 1'b0;
   logic [31:0]          alloc_pc = '0;
   logic [7:0]           alloc_op = '0;
   logic [4:0]           alloc_areg = '0;
   logic [6:0]           alloc_preg = '0;
   logic                 alloc_full, rob_empty;
   logic [6:0]           alloc_idx, rob_occupancy;
   logic                 disp_valid = 1'b0, cmpl_valid = 1'b0;
   logic [6:0]           disp_idx = '0, cmpl_idx = '0;
   logic                 disp_err, cmpl_err;
   logic [RW-1:0]        ret_valid;
   logic [RW-1:0][31:0]  ret_pc;
   logic [RW-1:0][7:0]   ret_op;
   logic [RW-1:0][4:0]   ret_areg;
   logic [RW-1:0][6:0]   ret_preg;

   uop_reorder_ring dut (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_pc(alloc_pc), .alloc_op(alloc_op),
      .alloc_areg(alloc_areg), .alloc_preg(alloc_preg),
      .alloc_full(alloc_full), .alloc_idx(alloc_idx),
      .rob_empty(rob_empty), .rob_occupancy(rob_occupancy),
      .disp_valid(disp_valid), .disp_idx(disp_idx),
      .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx),
      .disp_err(disp_err), .cmpl_err(cmpl_err),
      .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_op(ret_op),
      .ret_areg(ret_areg), .ret_preg(ret_preg));

   // Behavioural reference: 0 free, 1 waiting, 2 issued, 3 done.
   int          m_st [D];
   logic [31:0] m_pc [D];
   logic [7:0]  m_op [D];
   logic [4:0]  m_ar [D];
   logic [6:0]  m_pr [D];
   int m_head = 0, m_tail = 0, m_cnt = 0;
   bit e_derr = 0, e_cerr = 0;

   int n_cmp = 0, n_bad = 0;
   bit done_flag = 0;

   task automatic chk(input string req, input string what,
                      input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int pick_slot(input int want);
      int start;
      if (m_cnt == 0) return int'($urandom % 128);
      start = int'($urandom % m_cnt);
      for (int o = 0; o < m_cnt; o++) begin
         int s;
         s = (m_head + (start + o) % m_cnt) % D;
         if (m_st[s] == want) return s;
      end
      return int'($urandom % 128);
   endfunction

   task automatic compare_all();
      bit run;
      int s;
      chk("R3", "alloc_full", alloc_full, m_cnt == D);
      chk("R10", "rob_empty", rob_empty, m_cnt == 0);
      chk("R10", "rob_occupancy", rob_occupancy, m_cnt);
      chk("R2", "alloc_idx", alloc_idx, m_tail);
      chk("R8", "disp_err", disp_err, e_derr);
      chk("R9", "cmpl_err", cmpl_err, e_cerr);
      run = 1;
      for (int k = 0; k < RW; k++) begin
         s = (m_head + k) % D;
         run = run && (k < m_cnt) && (m_st[s] == 3);
         chk("R6 R7 R4 R5", $sformatf("ret_valid[%0d]", k), ret_valid[k], run);
         if (run && ret_valid[k]) begin
            chk("R6", "ret_pc", ret_pc[k], m_pc[s]);
            chk("R6", "ret_op", ret_op[k], m_op[s]);
            chk("R6", "ret_areg", ret_areg[k], m_ar[s]);
            chk("R6", "ret_preg", ret_preg[k], m_pr[s]);
         end
      end
   endtask

   task automatic cycle(input int p_alloc, input int p_disp, input int p_cmpl, input int p_bad);
      bit av, dv, cv, d_ok, c_ok;
      int di, ci, rc;
      logic [31:0] pc;
      logic [7:0] op;
      logic [4:0] ar;
      logic [6:0] pr;
      @(negedge clk);
      compare_all();
      av = int'($urandom % 100) < p_alloc;
      pc = $urandom; op = 8'($urandom); ar = 5'($urandom); pr = 7'($urandom);
      dv = int'($urandom % 100) < p_disp;
      cv = int'($urandom % 100) < p_cmpl;
      di = (int'($urandom % 100) < p_bad) ? int'($urandom % 128) : pick_slot(1);
      ci = (int'($urandom % 100) < p_bad) ? int'($urandom % 128) : pick_slot(2);
      // next state of the reference
      rc = 0;
      while (rc < RW && rc < m_cnt && m_st[(m_head + rc) % D] == 3) rc++;
      d_ok = dv && di < D && m_st[di] == 1;
      c_ok = cv && ci < D && m_st[ci] == 2;
      for (int k = 0; k < rc; k++) m_st[(m_head + k) % D] = 0;
      if (d_ok) m_st[di] = 2;
      if (c_ok) m_st[ci] = 3;
      if (av && m_cnt < D) begin
         m_st[m_tail] = 1;
         m_pc[m_tail] = pc; m_op[m_tail] = op; m_ar[m_tail] = ar; m_pr[m_tail] = pr;
         m_tail = (m_tail + 1) % D;
         m_cnt++;
      end
      m_head = (m_head + rc) % D;
      m_cnt -= rc;
      e_derr = dv && !d_ok;
      e_cerr = cv && !c_ok;
      alloc_valid = av; alloc_pc = pc; alloc_op = op; alloc_areg = ar; alloc_preg = pr;
      disp_valid = dv; disp_idx = 7'(di);
      cmpl_valid = cv; cmpl_idx = 7'(ci);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      if (!done_flag) begin
         n_bad++;
         $display("FAIL watchdog: run did not end");
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < D; i++) m_st[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1", "rob_empty", rob_empty, 1);
      chk("R1", "alloc_full", alloc_full, 0);
      chk("R1", "rob_occupancy", rob_occupancy, 0);
      chk("R1", "alloc_idx", alloc_idx, 0);
      chk("R1", "ret_valid", ret_valid, 0);
      chk("R1", "disp_err", disp_err, 0);
      chk("R1", "cmpl_err", cmpl_err, 0);
      rst_n = 1'b1;
      // fill to the brim, then offer more while full (R3)
      repeat (D + 12) cycle(100, 0, 0, 0);
      // progress reports only, with some misdirected (R4 R5 R7 R8 R9)
      repeat (500) cycle(0, 60, 60, 15);
      // mixed traffic wrapping the ring many times (R2 R6)
      repeat (4000) cycle(55, 75, 75, 10);
      // bursty allocation against fast completion
      repeat (1500) cycle(90, 95, 95, 5);
      // drain to empty
      repeat (800) cycle(0, 90, 90, 5);
      @(negedge clk);
      compare_all();
      done_flag = 1;
      finish_run();
   end

endmodule